// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Controller

This block watches a vector of already-synchronised GPIO input pins. For each pin it detects a programmable condition: a rising edge, a falling edge, either edge, a high level or a low level. When the condition occurs it latches a pending flag for that pin. Software reads the pending flags raw or filtered by a per-pin unmask vector, acknowledges flags by writing ones, and is alerted through two interrupt lines. One line covers the lower half of the pins and the other covers the upper half.

Each pin is configured through a 4-bit sense code held in a small bank of sense words, with eight pins packed into each word. A separate per-pin enable vector decides whether a pin may raise new pending flags. The unmask vector is changed only through two write-one ports, one that sets bits and one that clears them, so no read-modify-write is needed. Register reads return data one cycle after the read strobe.

Top module: `gis_ctrl`

## Requirements
- R1: After synchronous reset, the enable, unmask, pending and sense storage are all zero, both interrupt outputs are low and `rdata` is zero.
- R2: Pin n's sense code is bits [(n%8)*4+3:(n%8)*4] of the sense word at byte address 0x40 + 4*(n>>3). The four sense words are read/write.
- R3: Sense code 8 (rising) sets pin n's pending bit (bit n at raw status 0x20) on the clock edge where the pin is 1 and its previous sampled level was 0, and on no other transition.
- R4: Sense code 9 (falling) sets the pending bit only on a 1-to-0 transition of the pin.
- R5: Sense code 10 (high) and sense code 11 (low) set the pending bit on every clock while the level holds. An acknowledge therefore succeeds only after the level has gone inactive.
- R6: Sense code 12 (both edges) sets the pending bit on any change of the pin.
- R7: A sense code outside 8..12 produces no pending event for that pin.
- R8: The read/write enable vector at 0x14 gates detection. A pin whose enable bit is 0 raises no new pending bit, but a pending bit it already holds is kept.
- R9: Writing ones to 0x18 sets unmask bits and writing ones to 0x1C clears them. 0x18 reads the unmask vector and 0x24 reads pending AND unmask.
- R10: Writing ones to 0x28 clears those pending bits. If a new event hits the same pin in the same cycle, the bit stays set.
- R11: `irq_lo` is the OR of masked status bits 15:0 and `irq_hi` is the OR of bits 31:16. Both are registered and change on the same edge as the pending and unmask state.
- R12: Writing a sense word reloads the edge history of its eight pins from the current pin level. The write itself cannot produce an edge event.
- R13: Once every unmasked pending bit has been acknowledged, masked status reads zero and both interrupt lines are low. Servicing the lowest set bit repeatedly therefore terminates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronised GPIO input levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_lo | output | 1 | Interrupt for pins 15:0 |
| irq_hi | output | 1 | Interrupt for pins 31:16 |

## Verification
A corrupted pending latch or edge history shows up at raw status on the very next read, because every pin event lands in the pending vector on the edge where the pin level is sampled. A wrong unmask bit or interrupt register is visible on `irq_lo` or `irq_hi` in the cycle right after the edge that changed the state. A history that is not reloaded on a sense write shows up as a spurious raw bit one cycle after that write. Level modes are checked by acknowledging while the level is still active, which exposes any clear-over-event priority error immediately.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;
  localparam int unsigned SENSE_W = 4;

  localparam logic [7:0] OFS_ENABLE = 8'h14;
  localparam logic [7:0] OFS_UNMASK = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_MSTAT  = 8'h24;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_SENSE  = 8'h40;

  typedef enum logic [3:0] {
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  function automatic logic code_ok(input logic [3:0] c);
    return (c >= SNS_RISE) && (c <= SNS_BOTH);
  endfunction

  function automatic logic sense_fire(input logic [3:0] c, input logic now, input logic prev);
    case (c)
      SNS_RISE: return now & ~prev;
      SNS_FALL: return ~now & prev;
      SNS_HIGH: return now;
      SNS_LOW:  return ~now;
      SNS_BOTH: return now ^ prev;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gis_sense_bank.sv
`timescale 1ns/1ps
module gis_sense_bank #(
  parameter int NPINS   = 32,
  parameter int PER_REG = 8,
  parameter int FW      = 4,
  localparam int NREG   = NPINS / PER_REG,
  localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int RW     = PER_REG * FW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [IW-1:0]              idx,
  input  logic [RW-1:0]              wword,
  output logic [RW-1:0]              rword,
  output logic [NPINS-1:0][FW-1:0]   mode,
  output logic [NPINS-1:0]           reload
);
  logic [RW-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) bank[k] <= '0;
    end else if (wr) begin
      bank[idx] <= wword;
    end
  end

  assign rword = bank[idx];

  for (genvar n = 0; n < NPINS; n++) begin : g_field
    assign mode[n]   = bank[n / PER_REG][(n % PER_REG) * FW +: FW];
    assign reload[n] = wr && (idx == IW'(n / PER_REG));
  end
endmodule

// File: rtl/gis_pin_detect.sv
`timescale 1ns/1ps
module gis_pin_detect #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin,
  input  logic [FW-1:0] mode,
  input  logic          reload,
  input  logic          en,
  output logic          evt
);
  import gis_pkg::*;

  logic hist;

  // History follows the pin only while a valid mode is active; a sense
  // write reloads it so the newly selected mode starts from the live level.
  always_ff @(posedge clk) begin
    if (rst)                         hist <= 1'b0;
    else if (reload || code_ok(mode)) hist <= pin;
  end

  assign evt = en && sense_fire(mode, pin, hist);
endmodule

// File: rtl/gis_ctrl.sv
`timescale 1ns/1ps
module gis_ctrl #(
  parameter int NPINS   = 32,
  parameter int AW      = 8,
  parameter int PER_REG = 8,
  localparam int FW     = gis_pkg::SENSE_W,
  localparam int NREG   = NPINS / PER_REG,
  localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int HALF   = NPINS / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic             irq_lo,
  output logic             irq_hi
);
  import gis_pkg::*;

  localparam logic [AW-1:0] A_EN  = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_UM  = AW'(OFS_UNMASK);
  localparam logic [AW-1:0] A_MK  = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_RAW = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MS  = AW'(OFS_MSTAT);
  localparam logic [AW-1:0] A_ACK = AW'(OFS_ACK);
  localparam logic [AW-1:0] A_SNS = AW'(OFS_SENSE);

  logic [NPINS-1:0] en_q, um_q, pend_q;
  logic [NPINS-1:0] um_d, pend_d, clr, evt_w;
  logic [NPINS-1:0][FW-1:0] mode;
  logic [NPINS-1:0] reload;
  logic [NPINS-1:0] sense_rd;
  logic [AW-1:0]    soff;
  logic             s_hit;
  logic [IW-1:0]    sidx;
  logic [NPINS-1:0] rd_mux;

  assign soff  = addr - A_SNS;
  assign s_hit = (addr >= A_SNS) && (soff[AW-1:2] < (AW-2)'(NREG)) && (soff[1:0] == 2'b00);
  assign sidx  = soff[IW+1:2];

  gis_sense_bank #(.NPINS(NPINS), .PER_REG(PER_REG), .FW(FW)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en && s_hit),
    .idx   (sidx),
    .wword (wdata),
    .rword (sense_rd),
    .mode  (mode),
    .reload(reload)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    gis_pin_detect #(.FW(FW)) u_det (
      .clk   (clk),
      .rst   (rst),
      .pin   (pin_in[n]),
      .mode  (mode[n]),
      .reload(reload[n]),
      .en    (en_q[n]),
      .evt   (evt_w[n])
    );
  end

  assign clr    = (wr_en && addr == A_ACK) ? wdata : '0;
  assign pend_d = (pend_q & ~clr) | evt_w;

  always_comb begin
    um_d = um_q;
    if (wr_en && addr == A_UM)      um_d = um_q | wdata;
    else if (wr_en && addr == A_MK) um_d = um_q & ~wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (s_hit) rd_mux = sense_rd;
    else begin
      case (addr)
        A_EN:    rd_mux = en_q;
        A_UM:    rd_mux = um_q;
        A_RAW:   rd_mux = pend_q;
        A_MS:    rd_mux = pend_q & um_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      um_q   <= '0;
      pend_q <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en && addr == A_EN) en_q <= wdata;
      um_q   <= um_d;
      pend_q <= pend_d;
      irq_lo <= |(pend_d[HALF-1:0] & um_d[HALF-1:0]);
      irq_hi <= |(pend_d[NPINS-1:HALF] & um_d[NPINS-1:HALF]);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gis_ctrl_chk.sv
`timescale 1ns/1ps
module gis_ctrl_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  localparam int HALF = NPINS / 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pend_q,
  input logic [NPINS-1:0] um_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] evt,
  input logic             irq_lo,
  input logic             irq_hi
);
  localparam logic [AW-1:0] A_MK  = AW'(gis_pkg::OFS_MASK);
  localparam logic [AW-1:0] A_ACK = AW'(gis_pkg::OFS_ACK);

  assert_irq_lo_R11: assert property (@(posedge clk) disable iff (rst)
    irq_lo == |(pend_q[HALF-1:0] & um_q[HALF-1:0]));

  assert_irq_hi_R11: assert property (@(posedge clk) disable iff (rst)
    irq_hi == |(pend_q[NPINS-1:HALF] & um_q[NPINS-1:HALF]));

  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  assert_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MK) |=> ((um_q & $past(wdata)) == '0));

  assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ACK) |=> ((pend_q & $past(wdata) & ~$past(evt)) == '0));
endmodule

bind gis_ctrl gis_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .pend_q(pend_q),
  .um_q  (um_q),
  .en_q  (en_q),
  .evt   (evt_w),
  .irq_lo(irq_lo),
  .irq_hi(irq_hi)
);

// File: tb/sim_gis_ctrl.sv
`timescale 1ns/1ps
module sim_gis_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gis_ctrl u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  localparam logic [7:0] EN = 8'h14, UM = 8'h18, MK = 8'h1C, RAW = 8'h20,
                         MS = 8'h24, ACK = 8'h28, S0 = 8'h40, S1 = 8'h44, S2 = 8'h48;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk); pin_in[i] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
    chk("R1 irq_hi", {31'd0, irq_hi}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rd_chk("R1 enable", EN, 32'd0);
    rd_chk("R1 unmask", UM, 32'd0);
    rd_chk("R1 raw", RAW, 32'd0);
    rd_chk("R1 sense0", S0, 32'd0);
  endtask

  task automatic t_layout;
    wr(S0, 32'h000C_BA98);
    wr(S1, 32'h0000_D800);
    wr(S2, 32'h0008_0000);
    rd_chk("R2 sense0", S0, 32'h000C_BA98);
    rd_chk("R2 sense1", S1, 32'h0000_D800);
    rd_chk("R2 sense2", S2, 32'h0008_0000);
    rd_chk("R8 disabled low level", RAW, 32'd0);
  endtask

  task automatic t_edges;
    wr(EN, 32'h0010_0C17);
    set_pin(0, 1'b1); rd_chk("R3 rise", RAW, 32'h1);
    wr(ACK, 32'h1);
    set_pin(0, 1'b0); rd_chk("R3 no fall", RAW, 32'h0);
    set_pin(1, 1'b1); rd_chk("R4 no rise", RAW, 32'h0);
    set_pin(1, 1'b0); rd_chk("R4 fall", RAW, 32'h2);
    wr(ACK, 32'h2);
    set_pin(4, 1'b1); rd_chk("R6 rise", RAW, 32'h10);
    wr(ACK, 32'h10);
    set_pin(4, 1'b0); rd_chk("R6 fall", RAW, 32'h10);
    wr(ACK, 32'h10);  rd_chk("R10 ack", RAW, 32'h0);
  endtask

  task automatic t_level;
    set_pin(2, 1'b1); rd_chk("R5 high", RAW, 32'h4);
    wr(ACK, 32'h4);   rd_chk("R5 ack while high", RAW, 32'h4);
    set_pin(2, 1'b0);
    wr(ACK, 32'h4);   rd_chk("R5 ack after low", RAW, 32'h0);
    wr(EN, 32'h0010_0C1F);
    rd_chk("R5 low", RAW, 32'h8);
    set_pin(3, 1'b1);
    wr(ACK, 32'h8);   rd_chk("R5 low released", RAW, 32'h0);
    set_pin(3, 1'b0); rd_chk("R5 low again", RAW, 32'h8);
    wr(EN, 32'h0010_0C17);
    rd_chk("R8 kept while disabled", RAW, 32'h8);
    wr(ACK, 32'h8);   rd_chk("R8 no new event", RAW, 32'h0);
  endtask

  task automatic t_modes;
    set_pin(10, 1'b1);
    set_pin(11, 1'b1);
    rd_chk("R2 R7 field position and bad code", RAW, 32'h400);
    wr(ACK, 32'h400);
  endtask

  task automatic t_reload;
    wr(EN, 32'h0010_0C37);
    set_pin(5, 1'b1); rd_chk("R7 code zero", RAW, 32'h0);
    wr(S0, 32'h008C_BA98);
    rd_chk("R12 no false edge", RAW, 32'h0);
    set_pin(5, 1'b0);
    set_pin(5, 1'b1); rd_chk("R12 real edge", RAW, 32'h20);
    wr(ACK, 32'h20);
  endtask

  task automatic t_mask;
    wr(UM, 32'h0010_0001);
    rd_chk("R9 unmask read", UM, 32'h0010_0001);
    set_pin(0, 1'b1);
    chk("R11 irq_lo set", {31'd0, irq_lo}, 32'd1);
    chk("R11 irq_hi idle", {31'd0, irq_hi}, 32'd0);
    set_pin(20, 1'b1);
    chk("R11 irq_hi set", {31'd0, irq_hi}, 32'd1);
    rd_chk("R9 masked status", MS, 32'h0010_0001);
    wr(MK, 32'h1);
    chk("R11 irq_lo masked", {31'd0, irq_lo}, 32'd0);
    rd_chk("R9 masked after mask", MS, 32'h0010_0000);
    rd_chk("R9 raw after mask", RAW, 32'h0010_0001);
    rd_chk("R9 unmask after mask", UM, 32'h0010_0000);
    wr(UM, 32'h1);
    chk("R11 irq_lo unmasked", {31'd0, irq_lo}, 32'd1);
  endtask

  task automatic t_service;
    logic [31:0] v;
    int iters = 0;
    set_pin(4, 1'b1);
    rd_chk("R9 raw with masked bit", RAW, 32'h0010_0011);
    for (int k = 0; k < 8; k++) begin
      rd(MS, v);
      if (v == 0) break;
      for (int b = 0; b < 32; b++) begin
        if (v[b]) begin wr(ACK, 32'd1 << b); break; end
      end
      iters++;
    end
    chk("R13 iterations", iters, 2);
    rd_chk("R13 masked empty", MS, 32'h0);
    chk("R13 irq lines", {30'd0, irq_hi, irq_lo}, 32'd0);
    rd_chk("R13 masked-off bit kept", RAW, 32'h10);
  endtask

  task automatic t_race;
    set_pin(0, 1'b0);
    wr(ACK, 32'hFFFF_FFFF);
    rd_chk("R10 ack all", RAW, 32'h0);
    @(negedge clk); wr_en = 1'b1; addr = ACK; wdata = 32'h1; pin_in[0] = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd_chk("R10 event wins", RAW, 32'h1);
    chk("R11 irq_lo after race", {31'd0, irq_lo}, 32'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_edges();
    t_level();
    t_modes();
    t_reload();
    t_mask();
    t_service();
    t_race();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule